// File: doc/BRIEF.md
# Predicated Last-Element Extraction Unit

This unit picks one element out of a wide vector register, using a per-byte predicate mask, and returns it as a zero-extended 64-bit scalar. Elements can be 1, 2, 4 or 8 bytes wide. The unit first finds the highest active element of the vector. It then returns either that element ("before") or the element that follows it ("after"). The following element wraps around to the start of the vector.

Two modes are offered. In the unconditional mode an element is always produced, even when the predicate has no active lanes. In that case "after" returns element 0 and "before" returns the final element of the vector. In the conditional mode an empty predicate makes the unit return a caller-supplied fallback scalar instead, cut to the element width.

The vector length in bytes is a parameter. It may be any multiple of 16 up to 256, and it need not be a power of two. One request is accepted per cycle on a valid strobe. The result appears one cycle later, registered.

A two-state control machine tracks the output. IDLE goes to HOLD when a request is accepted (ACCEPT). HOLD stays in HOLD on a back-to-back request (REFILL). HOLD returns to IDLE when the strobe is low (DRAIN). IDLE stays in IDLE while no request arrives (WAIT).

Top module: `lastx_unit`

## Requirements
- R1: The size code `in_esz` selects the element width: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8. Element i occupies bytes i*w to i*w+w-1 of `in_vec`, little-endian, where byte b is bits 8b+7 to 8b. The result is zero-extended to 64 bits.
- R2: An element is active when `in_pred` is 1 at the element's lowest byte position. Predicate bits at the other byte positions of the element have no effect.
- R3: With `in_after`=0 and at least one active element, the result is the highest-numbered active element.
- R4: With `in_after`=1 and at least one active element, the result is the element just above the highest active one. When the highest active element is the last element of the vector, the result wraps to element 0. This holds for power-of-two and non-power-of-two lengths.
- R5: With `in_cond`=0, `in_after`=1 and no active element, the result is element 0.
- R6: With `in_cond`=0, `in_after`=0 and no active element, the result is the last element of the vector.
- R7: With `in_cond`=1 and no active element, the result is `in_fallback` with all bits above the element width cleared. This holds for either value of `in_after`.
- R8: With `in_cond`=1 and at least one active element, the result is the same element the unconditional mode would select.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_data` changes only after an accepted request. Reset clears `out_valid` and `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; inputs are sampled when high |
| in_vec | input | VL*8 | Source vector, byte b at bits 8b+7:8b |
| in_pred | input | VL | One predicate bit per vector byte |
| in_esz | input | 2 | Element size code (0..3 for 1/2/4/8 bytes) |
| in_after | input | 1 | 1: element after the last active one; 0: the last active one |
| in_cond | input | 1 | 1: conditional mode using the fallback |
| in_fallback | input | 64 | Scalar returned in conditional mode when nothing is active |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | 64 | Zero-extended selected element or fallback |

## Verification
The hardest case to reach is the wrap of the "after" offset through the compare-and-select path. That path exists only when the vector length is not a power of two. The highest active element must also sit exactly at the vector's top. The bench therefore runs a second instance with a 48-byte vector and places the lone predicate bit on the last element's base byte for both 4-byte and 8-byte elements.

Predicates that set only the non-base bytes of each element are also applied. These show that such bits leave the unit in its empty-predicate behaviour.

// File: rtl/lastx_pkg.sv
package lastx_pkg;

    typedef enum logic [1:0] {
        ESZ_1B = 2'd0,
        ESZ_2B = 2'd1,
        ESZ_4B = 2'd2,
        ESZ_8B = 2'd3
    } esz_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } state_e;

    // Clear every bit above the element width selected by the size code.
    function automatic logic [63:0] zext_elem(input logic [63:0] v, input logic [1:0] esz);
        logic [63:0] r;
        unique case (esz_e'(esz))
            ESZ_1B: r = {56'd0, v[7:0]};
            ESZ_2B: r = {48'd0, v[15:0]};
            ESZ_4B: r = {32'd0, v[31:0]};
            ESZ_8B: r = v;
            default: r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lastx_find.sv
// Highest active element search. The result is a byte offset
// (index times element bytes) in two's complement. When nothing is
// active the result is minus the element byte count.
module lastx_find #(
    parameter int VL = 32,
    parameter int OW = $clog2(VL) + 2
) (
    input  logic [VL-1:0] pred,
    input  logic [1:0]    esz,
    output logic [OW-1:0] last_ofs,
    output logic          found
);

    genvar s;
    generate
        for (s = 0; s < 4; s++) begin : g_sz
            localparam int EB = 1 << s;
            localparam int NE = VL / EB;
            logic [OW-1:0] ofs;
            logic          hit;
            always_comb begin
                ofs = '0;
                hit = 1'b0;
                for (int k = 0; k < NE; k++) begin
                    if (pred[k*EB]) begin
                        ofs = OW'(k * EB);
                        hit = 1'b1;
                    end
                end
            end
        end
    endgenerate

    logic [OW-1:0] eb;
    logic [OW-1:0] ofs_sel;

    always_comb begin
        eb = OW'(1) << esz;
        unique case (esz)
            2'd0: begin ofs_sel = g_sz[0].ofs; found = g_sz[0].hit; end
            2'd1: begin ofs_sel = g_sz[1].ofs; found = g_sz[1].hit; end
            2'd2: begin ofs_sel = g_sz[2].ofs; found = g_sz[2].hit; end
            default: begin ofs_sel = g_sz[3].ofs; found = g_sz[3].hit; end
        endcase
        last_ofs = found ? ofs_sel : (OW'(0) - eb);
    end

endmodule

// File: rtl/lastx_offset.sv
// Turns the search offset into the byte offset of the element to read.
module lastx_offset #(
    parameter int VL = 32,
    parameter int OW = $clog2(VL) + 2,
    parameter int IW = $clog2(VL)
) (
    input  logic [OW-1:0] last_ofs,
    input  logic          found,
    input  logic [1:0]    esz,
    input  logic          after,
    output logic [IW-1:0] sel
);

    localparam bit IS_POW2 = ((VL & (VL - 1)) == 0);

    logic [OW-1:0] eb;
    logic [OW-1:0] step;
    logic [IW-1:0] sel_after;
    logic [IW-1:0] sel_before;

    always_comb begin
        eb   = OW'(1) << esz;
        // not-found offset plus one element size lands on zero
        step = last_ofs + eb;
    end

    generate
        if (IS_POW2) begin : g_mask
            logic [OW-IW-1:0] unused_hi;
            assign unused_hi  = step[OW-1:IW];
            assign sel_after  = step[IW-1:0];
            assign sel_before = found ? last_ofs[IW-1:0] : (IW'(0) - eb[IW-1:0]);
        end else begin : g_cmp
            assign sel_after  = (step >= OW'(VL)) ? '0 : step[IW-1:0];
            assign sel_before = found ? last_ofs[IW-1:0] : (IW'(VL) - eb[IW-1:0]);
        end
    endgenerate

    assign sel = after ? sel_after : sel_before;

endmodule

// File: rtl/lastx_pick.sv
// Reads the element at a byte offset and zero-extends it.
module lastx_pick
    import lastx_pkg::*;
#(
    parameter int VL = 32,
    parameter int IW = $clog2(VL)
) (
    input  logic [VL*8-1:0] vec,
    input  logic [IW-1:0]   sel,
    input  logic [1:0]      esz,
    output logic [63:0]     elem
);

    logic [IW+2:0] shamt;
    logic [63:0]   raw;

    assign shamt = {sel, 3'b000};
    assign raw   = 64'(vec >> shamt);
    assign elem  = zext_elem(raw, esz);

endmodule

// File: rtl/lastx_unit.sv
module lastx_unit
    import lastx_pkg::*;
#(
    parameter int VL = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [VL*8-1:0] in_vec,
    input  logic [VL-1:0]   in_pred,
    input  logic [1:0]      in_esz,
    input  logic            in_after,
    input  logic            in_cond,
    input  logic [63:0]     in_fallback,
    output logic            out_valid,
    output logic [63:0]     out_data
);

    localparam int IW = $clog2(VL);
    localparam int OW = IW + 2;

    logic [OW-1:0] last_ofs;
    logic          found;
    logic [IW-1:0] sel;
    logic [63:0]   elem;
    logic [63:0]   result;

    state_e        state_q;
    state_e        state_d;
    logic [63:0]   data_q;

    lastx_find #(.VL(VL), .OW(OW)) u_find (
        .pred     (in_pred),
        .esz      (in_esz),
        .last_ofs (last_ofs),
        .found    (found)
    );

    lastx_offset #(.VL(VL), .OW(OW), .IW(IW)) u_offset (
        .last_ofs (last_ofs),
        .found    (found),
        .esz      (in_esz),
        .after    (in_after),
        .sel      (sel)
    );

    lastx_pick #(.VL(VL), .IW(IW)) u_pick (
        .vec  (in_vec),
        .sel  (sel),
        .esz  (in_esz),
        .elem (elem)
    );

    assign result = (in_cond && !found) ? zext_elem(in_fallback, in_esz) : elem;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;  // ACCEPT / WAIT
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;  // REFILL / DRAIN
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        data_q <= '0;
        else if (in_valid) data_q <= result;
    end

    assign out_valid = (state_q == ST_HOLD);
    assign out_data  = data_q;

endmodule

// File: rtl/lastx_unit_chk.sv
module lastx_unit_chk #(
    parameter int VL = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [VL*8-1:0] in_vec,
    input logic [VL-1:0]   in_pred,
    input logic [1:0]      in_esz,
    input logic            in_after,
    input logic            in_cond,
    input logic [63:0]     in_fallback,
    input logic            out_valid,
    input logic [63:0]     out_data
);

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |-> !out_valid);

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    assert_byte_zext_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_esz == 2'd0) |=> (out_data[63:8] == 56'd0));

    assert_empty_after_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_cond && in_after && in_esz == 2'd3 && in_pred == '0)
        |=> (out_data == $past(in_vec[63:0])));

    assert_empty_before_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_cond && !in_after && in_esz == 2'd3 && in_pred == '0)
        |=> (out_data == $past(in_vec[VL*8-1 -: 64])));

    assert_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cond && in_esz == 2'd0 && in_pred == '0)
        |=> (out_data == {56'd0, $past(in_fallback[7:0])}));

endmodule

bind lastx_unit lastx_unit_chk #(.VL(VL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_vec      (in_vec),
    .in_pred     (in_pred),
    .in_esz      (in_esz),
    .in_after    (in_after),
    .in_cond     (in_cond),
    .in_fallback (in_fallback),
    .out_valid   (out_valid),
    .out_data    (out_data)
);

// File: tb/lastx_unit_tb.sv
`timescale 1ns/1ps
module lastx_unit_tb;

    localparam int VLA = 32;
    localparam int VLB = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // default-length instance
    logic             a_valid = 1'b0;
    logic [VLA*8-1:0] a_vec;
    logic [VLA-1:0]   a_pred = '0;
    logic [1:0]       a_esz = '0;
    logic             a_after = 1'b0;
    logic             a_cond = 1'b0;
    logic [63:0]      a_fb = '0;
    logic             a_ovalid;
    logic [63:0]      a_odata;

    // non-power-of-two length instance
    logic             b_valid = 1'b0;
    logic [VLB*8-1:0] b_vec;
    logic [VLB-1:0]   b_pred = '0;
    logic [1:0]       b_esz = '0;
    logic             b_after = 1'b0;
    logic             b_cond = 1'b0;
    logic [63:0]      b_fb = '0;
    logic             b_ovalid;
    logic [63:0]      b_odata;

    lastx_unit #(.VL(VLA)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(a_valid), .in_vec(a_vec),
        .in_pred(a_pred), .in_esz(a_esz), .in_after(a_after), .in_cond(a_cond),
        .in_fallback(a_fb), .out_valid(a_ovalid), .out_data(a_odata)
    );

    lastx_unit #(.VL(VLB)) u_dut_np (
        .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_vec(b_vec),
        .in_pred(b_pred), .in_esz(b_esz), .in_after(b_after), .in_cond(b_cond),
        .in_fallback(b_fb), .out_valid(b_ovalid), .out_data(b_odata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [31:0] pred;
        logic [1:0]  esz;
        logic        after;
        logic        cond;
        logic [63:0] fb;
        int          idx;   // expected element index, -1 = fallback
        int          req;
    } row_t;

    localparam logic [63:0] FB = 64'h1122_3344_5566_7788;

    localparam row_t TBL [16] = '{
        '{32'h0000_0001, 2'd0, 1'b0, 1'b0, 64'd0, 0,  3},   // R3
        '{32'h0000_0100, 2'd0, 1'b1, 1'b0, 64'd0, 9,  4},   // R4
        '{32'h8000_0000, 2'd0, 1'b1, 1'b0, 64'd0, 0,  4},   // R4 wrap
        '{32'h8000_0000, 2'd0, 1'b0, 1'b0, 64'd0, 31, 3},   // R3
        '{32'h0000_0000, 2'd0, 1'b1, 1'b0, 64'd0, 0,  5},   // R5
        '{32'h0000_0000, 2'd0, 1'b0, 1'b0, 64'd0, 31, 6},   // R6
        '{32'h0000_0000, 2'd2, 1'b0, 1'b0, 64'd0, 7,  6},   // R6
        '{32'h0000_0000, 2'd3, 1'b0, 1'b1, FB,    -1, 7},   // R7
        '{32'h0000_0000, 2'd1, 1'b1, 1'b1, FB,    -1, 7},   // R7
        '{32'h0000_00FE, 2'd3, 1'b0, 1'b0, 64'd0, 3,  2},   // R2
        '{32'h0000_0102, 2'd1, 1'b0, 1'b0, 64'd0, 4,  2},   // R2
        '{32'h0001_0000, 2'd2, 1'b1, 1'b0, 64'd0, 5,  1},   // R1
        '{32'h0100_0001, 2'd3, 1'b1, 1'b0, 64'd0, 0,  4},   // R4 wrap
        '{32'h0000_0011, 2'd2, 1'b0, 1'b1, FB,    1,  8},   // R8
        '{32'h0000_0011, 2'd2, 1'b1, 1'b1, FB,    2,  8},   // R8
        '{32'hFFFF_FFFF, 2'd0, 1'b0, 1'b0, 64'd0, 31, 3}    // R3
    };

    function automatic logic [VLB*8-1:0] pattern();
        logic [VLB*8-1:0] v;
        for (int b = 0; b < VLB; b++) v[b*8 +: 8] = 8'((b * 17 + 5) & 255);
        return v;
    endfunction

    function automatic logic [63:0] elem_of(input logic [VLB*8-1:0] v, input int idx, input int eb);
        logic [63:0] r = '0;
        for (int j = 0; j < eb; j++) r[j*8 +: 8] = v[(idx*eb + j)*8 +: 8];
        return r;
    endfunction

    function automatic logic [63:0] fb_cut(input logic [63:0] f, input int eb);
        return (eb == 8) ? f : (f & ((64'd1 << (eb*8)) - 64'd1));
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_a(input row_t r, input string tag);
        logic [63:0] exp;
        int eb = 1 << r.esz;
        exp = (r.idx < 0) ? fb_cut(r.fb, eb) : elem_of(pattern(), r.idx, eb);
        @(negedge clk);
        a_pred = r.pred; a_esz = r.esz; a_after = r.after; a_cond = r.cond; a_fb = r.fb;
        a_valid = 1'b1;
        @(negedge clk);
        a_valid = 1'b0;
        check({tag, " valid (R9)"}, {63'd0, a_ovalid}, 64'd1);
        check(tag, a_odata, exp);
    endtask

    task automatic run_b(input logic [VLB-1:0] p, input logic [1:0] esz, input logic after,
                         input int idx, input string tag);
        int eb = 1 << esz;
        @(negedge clk);
        b_pred = p; b_esz = esz; b_after = after; b_cond = 1'b0; b_fb = '0;
        b_valid = 1'b1;
        @(negedge clk);
        b_valid = 1'b0;
        check(tag, b_odata, elem_of(pattern(), idx, eb));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        a_vec = pattern()[VLA*8-1:0];
        b_vec = pattern();
        repeat (3) @(negedge clk);
        check("R9 reset out_valid", {63'd0, a_ovalid}, 64'd0);
        check("R9 reset out_data", a_odata, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle out_valid", {63'd0, a_ovalid}, 64'd0);

        for (int i = 0; i < 16; i++) begin
            run_a(TBL[i], $sformatf("R%0d table row %0d", TBL[i].req, i));
        end

        // R9: output drops and data holds once the strobe is low
        held = a_odata;
        @(negedge clk);
        check("R9 out_valid drops", {63'd0, a_ovalid}, 64'd0);
        a_pred = 32'h0000_0004;
        @(negedge clk);
        check("R9 data held without strobe", a_odata, held);

        // R7: byte-wide fallback with after select
        run_a('{32'h0, 2'd0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFAB, -1, 7}, "R7 byte fallback");
        // R2: only non-base bytes of 2-byte elements set
        run_a('{32'hAAAA_AAAA, 2'd1, 1'b1, 1'b0, 64'd0, 0, 2}, "R2 odd bytes ignored");

        // R4 and R6 on a 48-byte vector (compare-select wrap)
        run_b(48'h0100_0000_0000, 2'd3, 1'b1, 0,  "R4 np wrap 8B");
        run_b(48'h0000_0000_0000, 2'd3, 1'b0, 5,  "R6 np last 8B");
        run_b(48'h0100_0000_0000, 2'd2, 1'b1, 11, "R4 np next 4B");
        run_b(48'h1000_0000_0000, 2'd2, 1'b1, 0,  "R4 np wrap 4B");
        run_b(48'h0000_0000_0000, 2'd0, 1'b0, 47, "R6 np last 1B");
        run_b(48'h0000_0000_0000, 2'd1, 1'b1, 0,  "R5 np empty after");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule